// File: doc/BRIEF.md
# Memory-Based Interrupt Reporter

This block lets a device report interrupt events to a host through shared memory instead of through a status register. Up to 64 reporting units each present a 16-bit event vector together with their unit index. The block holds these events in a per-unit pending store. It then runs one report sequence per unit.

Each sequence starts by reading a 16-bit enable word from memory. The block writes a marker byte for every event bit that is both set and enabled into a per-unit slot of a status area. It then writes a marker byte for the unit into a source area. Last, it pulses a one-cycle interrupt to the host.

Memory is reached through a single request/acknowledge port. That port carries byte writes and 16-bit word reads. Both area bases are inputs, and the block refuses to run while either base breaks its alignment rule.

The controller is a five-state machine:

- **S_IDLE** waits for pending work. It takes the transition *start* to **S_MASK** when a unit has pending events and both bases are aligned. That transition moves the lowest-numbered pending unit's vector into the working register.
- **S_MASK** issues the enable-word read.
  - On acknowledge it takes *all_masked* back to **S_IDLE** if no enabled bit remains.
  - Otherwise it takes *have_bits* to **S_STAT**.
- **S_STAT** writes one status byte per acknowledge, lowest bit first.
  - It takes *stat_next* back to itself while bits remain.
  - It takes *stat_done* to **S_SRC** after the last bit.
- **S_SRC** writes the source byte and takes *src_done* to **S_IRQ** on acknowledge.
- **S_IRQ** drives the host interrupt for one cycle and takes *irq_done* to **S_IDLE**.

Top module: `mirq_reporter`

## Requirements
- R1: After reset, `mem_req` and `host_irq` are low, and no sequence runs until an event is accepted.
- R2: Every memory write carries the data byte 0xFF.
- R3: For unit u, each bit b that is set in both the captured vector and the enable word produces one write at `status_base + 16*u + b`. These writes are issued in ascending b order, and bits that are clear in either produce no write.
- R4: Every sequence begins with one word read (`mem_we` low) at `source_base + 0x40`. The 16-bit `mem_rdata` returned with its acknowledge is the enable word: bit b set enables event bit b.
- R5: After the last status write of a sequence is acknowledged, one write is issued at `source_base + u`. No other write of that sequence follows it.
- R6: `host_irq` is high for exactly one cycle, the cycle after the source write is acknowledged. It is never high at any other time.
- R7: If the captured vector ANDed with the enable word is zero, the sequence ends after the read with no write and no interrupt.
- R8: `cfg_err` is high exactly when `status_base[11:0]` or `source_base[5:0]` is nonzero. While it is high no new sequence starts, and pending events are kept.
- R9: Events accepted while a sequence runs are kept per unit and reported by a later sequence. Bits for the same unit accepted at different times are merged into one vector.
- R10: When several units are pending, the lowest unit index is reported first.
- R11: A request stays asserted with unchanged address and direction until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | An event vector is offered this cycle |
| evt_unit | input | 6 | Index of the reporting unit |
| evt_vec | input | 16 | Event bits raised by that unit |
| status_base | input | 32 | Base address of the status area (4 KiB aligned) |
| source_base | input | 32 | Base address of the source area (64-byte aligned); enable word at +0x40 |
| cfg_err | output | 1 | A base address is misaligned |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = byte write, 0 = word read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| mem_rdata | input | 16 | Read word, valid with `mem_ack` |
| host_irq | output | 1 | One-cycle interrupt to the host |

## Verification
The assertions rely on two assumptions about the memory side:

- `mem_ack` arrives only while `mem_req` is high.
- `mem_ack` lasts exactly one cycle.

The bench responder meets both. It acknowledges only an open request, waits zero to two cycles before doing so, and always drops the acknowledge on the following cycle.

Events are offered only at times the bench can pin to a state:

- while the machine is idle and has nothing pending;
- while a base is misaligned;
- while a status write is outstanding.

This keeps the bench's own choice of the next unit consistent with the moment the block captures its vector.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MASK,
        S_STAT,
        S_SRC,
        S_IRQ
    } mirq_state_e;

    localparam logic [7:0] MARK_BYTE = 8'hFF;

endpackage

// File: rtl/mirq_lsb_find.sv
module mirq_lsb_find #(
    parameter int W  = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set bit is the last one kept.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/mirq_pend_bank.sv
module mirq_pend_bank #(
    parameter int N_UNITS = 64,
    parameter int VEC_W   = 16,
    localparam int UNIT_W = $clog2(N_UNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld,
    input  logic [UNIT_W-1:0] set_unit,
    input  logic [VEC_W-1:0]  set_vec,
    input  logic              clr_vld,
    input  logic [UNIT_W-1:0] clr_unit,
    output logic              any,
    output logic [UNIT_W-1:0] sel_unit,
    output logic [VEC_W-1:0]  sel_vec
);

    logic [VEC_W-1:0]   pend_q [N_UNITS];
    logic [N_UNITS-1:0] nz;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        logic hit_set;
        logic hit_clr;
        assign hit_set = set_vld && (set_unit == UNIT_W'(u));
        assign hit_clr = clr_vld && (clr_unit == UNIT_W'(u));

        // A new event wins over a clear in the same cycle, so nothing is lost.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[u] <= '0;
            end else if (hit_set || hit_clr) begin
                pend_q[u] <= (hit_clr ? '0 : pend_q[u]) | (hit_set ? set_vec : '0);
            end
        end

        assign nz[u] = |pend_q[u];
    end

    mirq_lsb_find #(.W(N_UNITS)) u_unit_pick (
        .vec   (nz),
        .found (any),
        .idx   (sel_unit)
    );

    assign sel_vec = pend_q[sel_unit];

    // R9
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld && (|set_vec)) |=> any);

endmodule

// File: rtl/mirq_reporter.sv
module mirq_reporter
    import mirq_pkg::*;
#(
    parameter int N_UNITS       = 64,
    parameter int VEC_W         = 16,
    parameter int ADDR_W        = 32,
    parameter int STAT_ALIGN_LG = 12,
    parameter int SRC_ALIGN_LG  = 6,
    localparam int UNIT_W       = $clog2(N_UNITS),
    localparam int BIT_W        = $clog2(VEC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [UNIT_W-1:0] evt_unit,
    input  logic [VEC_W-1:0]  evt_vec,
    input  logic [ADDR_W-1:0] status_base,
    input  logic [ADDR_W-1:0] source_base,
    output logic              cfg_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [VEC_W-1:0]  mem_rdata,
    output logic              host_irq
);

    // One marker byte per unit, so the enable word sits right after the source area.
    localparam int MASK_OFS = N_UNITS;

    mirq_state_e state_q, state_d;

    logic [UNIT_W-1:0] unit_q;
    logic [VEC_W-1:0]  work_q;
    logic              pend_any;
    logic [UNIT_W-1:0] pend_unit;
    logic [VEC_W-1:0]  pend_vec;
    logic              start;
    logic              bit_found;
    logic [BIT_W-1:0]  bit_idx;
    logic [VEC_W-1:0]  work_rest;
    logic [VEC_W-1:0]  work_masked;
    logic [ADDR_W-1:0] stat_addr;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] mask_addr;

    assign cfg_err = (|status_base[STAT_ALIGN_LG-1:0]) || (|source_base[SRC_ALIGN_LG-1:0]);
    assign start   = (state_q == S_IDLE) && pend_any && !cfg_err;

    mirq_pend_bank #(.N_UNITS(N_UNITS), .VEC_W(VEC_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (evt_valid),
        .set_unit (evt_unit),
        .set_vec  (evt_vec),
        .clr_vld  (start),
        .clr_unit (pend_unit),
        .any      (pend_any),
        .sel_unit (pend_unit),
        .sel_vec  (pend_vec)
    );

    mirq_lsb_find #(.W(VEC_W)) u_bit_pick (
        .vec   (work_q),
        .found (bit_found),
        .idx   (bit_idx)
    );

    assign work_rest   = work_q & ~(VEC_W'(1) << bit_idx);
    assign work_masked = work_q & mem_rdata;

    // Each unit owns a VEC_W-byte slot in the status area.
    assign stat_addr = status_base + (ADDR_W'(unit_q) << BIT_W) + ADDR_W'(bit_idx);
    assign src_addr  = source_base + ADDR_W'(unit_q);
    assign mask_addr = source_base + ADDR_W'(MASK_OFS);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start)   state_d = S_MASK;
            S_MASK: if (mem_ack) state_d = (work_masked == '0) ? S_IDLE : S_STAT;
            S_STAT: if (mem_ack && (work_rest == '0)) state_d = S_SRC;
            S_SRC:  if (mem_ack) state_d = S_IRQ;
            S_IRQ:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_q <= '0;
            work_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    unit_q <= pend_unit;
                    work_q <= pend_vec;
                end
                S_MASK: if (mem_ack) work_q <= work_masked;
                S_STAT: if (mem_ack) work_q <= work_rest;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        host_irq  = 1'b0;
        unique case (state_q)
            S_MASK: begin
                mem_req  = 1'b1;
                mem_addr = mask_addr;
            end
            S_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stat_addr;
                mem_wdata = MARK_BYTE;
            end
            S_SRC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = src_addr;
                mem_wdata = MARK_BYTE;
            end
            S_IRQ:   host_irq = 1'b1;
            default: ;
        endcase
    end

    // Input assumption on the memory port
    ack_only_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> mem_req);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6
    irq_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> ($past(mem_ack) && $past(mem_we)));

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !host_irq);

    // R7
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_MASK) && mem_ack && (work_masked == '0)) |=> (!mem_req && !host_irq));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && cfg_err) |=> !mem_req);

    // R3
    stat_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STAT) |-> bit_found);

endmodule

// File: tb/mirq_reporter_tb.sv
`timescale 1ns/1ps
module mirq_reporter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [5:0]  evt_unit = '0;
    logic [15:0] evt_vec = '0;
    logic [31:0] stat_b = 32'h0001_0000;
    logic [31:0] src_b  = 32'h0001_0400;
    logic        cfg_err, mem_req, mem_we, host_irq;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    mirq_reporter dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_unit(evt_unit),
        .evt_vec(evt_vec), .status_base(stat_b), .source_base(src_b),
        .cfg_err(cfg_err), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .host_irq(host_irq)
    );

    int vecs = 0;
    int fails = 0;
    int req_seen = 0;
    logic [15:0] tb_mask = 16'hFFFF;
    int pend_m [64];
    int exp_kind [$];   // 0 read, 1 write, 2 irq
    int exp_addr [$];
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] expv);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, expv, $time);
        end
    endtask

    function automatic bit pend_empty();
        for (int u = 0; u < 64; u++) if (pend_m[u] != 0) return 0;
        return 1;
    endfunction

    // Reference model, monitor and memory responder in one ordered process
    bit open = 0;
    int cnt = 0;
    int dly = 0;
    logic [31:0] open_addr;
    always @(negedge clk) begin
        bit was_ack;
        was_ack = mem_ack;
        if (mem_ack) mem_ack = 1'b0;
        if (rst_n) begin
            if (host_irq) begin
                if (exp_kind.size() != 0 && exp_kind[0] == 2) begin
                    void'(exp_kind.pop_front()); void'(exp_addr.pop_front());
                    chk(1, "R6 irq", 1, 1);
                end else chk(0, "R6 unexpected irq", 1, 0);
            end
            if (mem_req && !open) begin
                open = 1; open_addr = mem_addr; cnt = dly; dly = (dly + 1) % 3;
                req_seen++;
                if (!mem_we && exp_kind.size() == 0) begin
                    int su; int v;
                    su = -1;
                    for (int u = 63; u >= 0; u--) if (pend_m[u] != 0) su = u;
                    if (su < 0) chk(0, "R10 read with nothing pending", mem_addr, 0);
                    else begin
                        v = pend_m[su] & int'(tb_mask);
                        pend_m[su] = 0;
                        exp_kind.push_back(0); exp_addr.push_back(int'(src_b + 32'h40));
                        for (int b = 0; b < 16; b++) if (v[b]) begin
                            exp_kind.push_back(1); exp_addr.push_back(int'(stat_b) + su * 16 + b);
                        end
                        if (v != 0) begin
                            exp_kind.push_back(1); exp_addr.push_back(int'(src_b) + su);
                            exp_kind.push_back(2); exp_addr.push_back(0);
                        end
                    end
                end
                if (exp_kind.size() == 0) chk(0, "R7 unexpected request", mem_addr, 0);
                else begin
                    int k; int a;
                    k = exp_kind.pop_front(); a = exp_addr.pop_front();
                    if (k == 2) chk(0, "R6 request where irq due", mem_addr, 32'(a));
                    else if (k == 0) chk(!mem_we && mem_addr == 32'(a), "R4 enable read", mem_addr, 32'(a));
                    else if (32'(a) < stat_b + 32'd1024)
                        chk(mem_we && mem_addr == 32'(a), "R3 status write", mem_addr, 32'(a));
                    else
                        chk(mem_we && mem_addr == 32'(a), "R5 source write", mem_addr, 32'(a));
                    if (mem_we) chk(mem_wdata == 8'hFF, "R2 marker byte", 32'(mem_wdata), 32'hFF);
                end
            end
            if (!was_ack && open) begin
                if (cnt == 0) begin
                    chk(mem_req && mem_addr == open_addr, "R11 request held", mem_addr, open_addr);
                    mem_ack = 1'b1; mem_rdata = tb_mask; open = 0;
                end else cnt--;
            end
        end
    end

    task automatic inject(input int u, input logic [15:0] v);
        @(negedge clk);
        evt_valid = 1'b1; evt_unit = 6'(u); evt_vec = v;
        pend_m[u] = pend_m[u] | int'(v);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wait_stat_write();
        do @(negedge clk); while (!(mem_req && mem_we && mem_addr < stat_b + 32'd1024));
    endtask

    task automatic drain(input string tag);
        int quiet = 0;
        for (int i = 0; i < 3000 && quiet < 8; i++) begin
            @(negedge clk);
            if (exp_kind.size() == 0 && !mem_req && !host_irq && pend_empty()) quiet++;
            else quiet = 0;
        end
        chk(exp_kind.size() == 0 && pend_empty(), tag, 32'(exp_kind.size()), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int snap;
        for (int u = 0; u < 64; u++) pend_m[u] = 0;
        repeat (4) @(negedge clk);
        chk(!mem_req && !host_irq, "R1 in reset", {30'b0, mem_req, host_irq}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!mem_req && !host_irq && !cfg_err, "R1 after reset idle", {29'b0, cfg_err, mem_req, host_irq}, 0);

        // Single events, full enable
        inject(0, 16'h0001);   drain("R3 unit 0 bit 0 drained");
        inject(63, 16'h8001);  drain("R3 unit 63 edge bits drained");
        inject(17, 16'hA5A5);  drain("R5 pattern drained");

        // Partial enable word
        tb_mask = 16'h00F0;
        inject(10, 16'hFFFF);  drain("R3 enable subset drained");
        // All masked off
        tb_mask = 16'h0000;
        inject(7, 16'h0003);   drain("R7 masked sequence drained");
        tb_mask = 16'h0F00;
        inject(8, 16'h00FF);   drain("R7 disjoint mask drained");
        tb_mask = 16'hFFFF;

        // Misaligned status base holds everything, then lowest unit first
        @(negedge clk); stat_b = 32'h0001_0004;
        @(negedge clk); chk(cfg_err, "R8 status misaligned flag", {31'b0, cfg_err}, 1);
        snap = req_seen;
        inject(40, 16'h0002); inject(3, 16'h0010); inject(63, 16'h4000);
        repeat (30) @(negedge clk);
        chk(req_seen == snap, "R8 no request while misaligned", 32'(req_seen - snap), 0);
        stat_b = 32'h0001_0000;
        @(negedge clk); chk(!cfg_err, "R8 flag clears", {31'b0, cfg_err}, 0);
        drain("R10 lowest unit order drained");

        // Misaligned source base
        @(negedge clk); src_b = 32'h0001_0420;
        @(negedge clk); chk(cfg_err, "R8 source misaligned flag", {31'b0, cfg_err}, 1);
        snap = req_seen;
        inject(12, 16'h0001);
        repeat (20) @(negedge clk);
        chk(req_seen == snap, "R8 source misaligned holds", 32'(req_seen - snap), 0);
        src_b = 32'h0001_0400;
        drain("R8 retained event reported");

        // Events during a busy sequence are queued and merged
        inject(5, 16'h00FF);
        wait_stat_write();
        inject(5, 16'h0300);
        inject(2, 16'h0001);
        inject(9, 16'h0001);
        inject(9, 16'h0100);
        drain("R9 queued and merged events drained");

        // Other base pair
        stat_b = 32'h0002_3000; src_b = 32'h0002_3040;
        inject(33, 16'h0810); drain("R4 relocated areas drained");
        finish_run();
    end

endmodule